// File: doc/BRIEF.md
# DMA Request Priority and Mask Unit

This unit decides which of four DMA channels is served next. Each channel can be requested by a hardware request pin or by a bit in a software request register. Hardware pins pass through a per-channel mask, and software bits count only for channels set up for block transfers. The eligible requests go to a priority picker. The picker runs either a fixed order or a rotating order in which the channel served last drops to the bottom. The host programs the unit through a small register-write port. It reads a status byte that gathers the per-channel terminal-count flags and the pending requests.

A separate transfer sequencer uses the unit. When `req_valid` is high it raises `svc_start`, and the channel on `win_ch` is then frozen until `svc_done`. While the service runs, the acknowledge line of that channel is driven at its programmed polarity. The sequencer reports a terminal count or an external end of process for the channel in service. The unit then updates the flags, request bits and mask bits of that channel.

Top module: `dma_req_arbiter`

## Requirements
- R1: In fixed order (command bit 4 = 0) the lowest-numbered eligible channel wins, so channel 0 is first and channel 3 is last.
- R2: In rotating order (command bit 4 = 1), when a service of channel k ends, channel k+1 (wrapping 3 to 0) becomes highest priority and channel k becomes lowest.
- R3: Command bit 6 = 1 makes the `dreq_in` pins active-low. When it is 0 they are active-high.
- R4: During a service only the served channel's `dack_out` bit is active. The active level is high when command bit 7 = 1 and low when it is 0. All other bits stay at the inactive level.
- R5: Reset sets all four mask bits, and a masked hardware request is ignored. A write to address 4'b1010 sets (data bit 2 = 1) or clears (data bit 2 = 0) the mask bit of the channel in data bits 1:0. Address 4'b1111 loads data bits 3:0 into the mask. Address 4'b1110 clears the whole mask.
- R6: A write to address 4'b1001 sets or resets the software request bit of the channel in data bits 1:0, using data bit 2. That bit makes the channel eligible, regardless of its mask bit, only while the channel's mode is block. A mode write is at address 4'b1011, with the channel in data bits 1:0, auto-init in data bit 4, and block mode when data bits 7:6 = 2'b10.
- R7: A terminal count or end of process (`tc_hit` or `eop_hit` during a service) sets that channel's status flag and clears its software request bit. It also sets its mask bit unless the channel has auto-init enabled.
- R8: `status_rdata` bits 3:0 are the terminal-count flags and bits 7:4 are the pending requests (polarity-corrected pin or software bit, unmasked). A status read (`reg_rd` at address 4'b1000) clears bits 3:0.
- R9: Command bit 2 = 1 (command written at address 4'b1000) blocks all grants. `req_valid` stays low and no service can start.
- R10: From `svc_start` to `svc_done` the outputs `win_ch` and `dack_out` are held for the granted channel, and `req_valid` is low, whatever the request inputs do.
- R11: A write to address 4'b1101 clears the command, the software requests and the status flags. It sets all mask bits, ends any service, and puts the rotating pointer back to channel 0 first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 4 | Register / command address |
| reg_wdata | input | 8 | Write data |
| status_rdata | output | 8 | Status byte: pending requests (7:4), terminal-count flags (3:0) |
| dreq_in | input | 4 | Raw hardware request pins |
| svc_start | input | 1 | Sequencer begins serving the current winner |
| svc_done | input | 1 | Sequencer finished the current service |
| tc_hit | input | 1 | Terminal count reached on the channel in service |
| eop_hit | input | 1 | External end of process on the channel in service |
| req_valid | output | 1 | A grantable request exists and the unit is idle |
| win_ch | output | 2 | Winning channel, or the held channel during a service |
| dack_out | output | 4 | Acknowledge lines at programmed polarity |

## Verification
The hardest condition to reach is the wrap of the rotating pointer from channel 3 back to channel 0. The pointer is also expected to survive a master clear only as the plain fixed order. The stimulus keeps all four requests asserted in rotating mode and runs one complete service per step, so the pointer walks through every channel and wraps. A master clear is then issued while the pointer is off zero, and rotating mode is re-enabled to show that channel 0 leads again. Auto-init versus non-auto-init end of process is reached by setting up block and auto-init modes before the service in which the event is pulsed.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
  typedef enum logic [3:0] {
    ADR_CMD     = 4'b1000,
    ADR_REQ     = 4'b1001,
    ADR_SMASK   = 4'b1010,
    ADR_MODE    = 4'b1011,
    ADR_MCLR    = 4'b1101,
    ADR_CLRMASK = 4'b1110,
    ADR_AMASK   = 4'b1111
  } arb_addr_e;

  localparam int unsigned CMD_DIS_BIT   = 2;
  localparam int unsigned CMD_ROT_BIT   = 4;
  localparam int unsigned CMD_DREQL_BIT = 6;
  localparam int unsigned CMD_DACKH_BIT = 7;
endpackage

// File: rtl/dma_prio_pick.sv
module dma_prio_pick #(
  parameter int unsigned NCH = 4,
  localparam int unsigned CW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic [NCH-1:0] elig,
  input  logic           rotate,
  input  logic [CW-1:0]  top,
  output logic           any,
  output logic [CW-1:0]  sel
);
  // Channel index at search position i, starting from base, wrapping at NCH.
  function automatic logic [CW-1:0] ch_at(input logic [CW-1:0] base, input int i);
    return CW'((int'(base) + i) % NCH);
  endfunction

  always_comb begin
    logic [CW-1:0] base;
    logic [CW-1:0] idx;
    base = rotate ? top : '0;
    any  = 1'b0;
    sel  = '0;
    for (int i = 0; i < NCH; i++) begin
      idx = ch_at(base, i);
      if (!any && elig[idx]) begin
        any = 1'b1;
        sel = idx;
      end
    end
  end
endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dma_arb_pkg::*;
#(
  parameter int unsigned NCH = 4,
  localparam int unsigned CW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr,
  input  logic           rd_stat,
  input  logic           mclr,
  input  logic [3:0]     addr,
  input  logic [7:0]     wdata,
  input  logic           evt,
  input  logic [CW-1:0]  evt_ch,
  output logic [NCH-1:0] mask,
  output logic [NCH-1:0] req_sw,
  output logic [NCH-1:0] blk,
  output logic [NCH-1:0] tc_flags
);
  logic [NCH-1:0] auto_q;
  logic [CW-1:0]  wch;
  logic           unused_wdata;

  assign wch          = wdata[CW-1:0];
  assign unused_wdata = wdata[5];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask     <= '1;
      req_sw   <= '0;
      tc_flags <= '0;
      blk      <= '0;
      auto_q   <= '0;
    end else if (mclr) begin
      mask     <= '1;
      req_sw   <= '0;
      tc_flags <= '0;
    end else begin
      if (wr) begin
        unique case (addr)
          ADR_SMASK:   mask[wch] <= wdata[2];
          ADR_AMASK:   mask      <= wdata[NCH-1:0];
          ADR_CLRMASK: mask      <= '0;
          ADR_REQ:     req_sw[wch] <= wdata[2];
          ADR_MODE: begin
            blk[wch]    <= (wdata[7:6] == 2'b10);
            auto_q[wch] <= wdata[4];
          end
          default: ;
        endcase
      end
      if (rd_stat) tc_flags <= '0;
      // End-of-process events take priority over same-cycle writes and reads.
      if (evt) begin
        tc_flags[evt_ch] <= 1'b1;
        req_sw[evt_ch]   <= 1'b0;
        if (!auto_q[evt_ch]) mask[evt_ch] <= 1'b1;
      end
    end
  end

  assert_evt_effect_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(evt) && !$past(mclr)) |-> (tc_flags[$past(evt_ch)] && !req_sw[$past(evt_ch)]));

  assert_status_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rd_stat) && !$past(evt)) |-> (tc_flags == '0));

  assert_mclr_mask_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $past(mclr) |-> (mask == '1 && req_sw == '0));
endmodule

// File: rtl/dma_req_arbiter.sv
module dma_req_arbiter
  import dma_arb_pkg::*;
#(
  parameter int unsigned NCH = 4,
  localparam int unsigned CW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic [3:0]       reg_addr,
  input  logic [7:0]       reg_wdata,
  output logic [2*NCH-1:0] status_rdata,
  input  logic [NCH-1:0]   dreq_in,
  input  logic             svc_start,
  input  logic             svc_done,
  input  logic             tc_hit,
  input  logic             eop_hit,
  output logic             req_valid,
  output logic [CW-1:0]    win_ch,
  output logic [NCH-1:0]   dack_out
);
  function automatic logic [CW-1:0] next_ch(input logic [CW-1:0] c);
    return (int'(c) == NCH - 1) ? '0 : c + 1'b1;
  endfunction

  logic           dis_q, rot_q, dreq_lo_q, dack_hi_q;
  logic           busy_q;
  logic [CW-1:0]  held_q, top_q;
  logic [NCH-1:0] mask, req_sw, blk, tc_flags;
  logic [NCH-1:0] dreq_eff, elig, dack_act;
  logic           pick_any, svc_take, evt, mclr_w, rd_stat;
  logic [CW-1:0]  pick_sel;

  assign mclr_w   = reg_wr && (reg_addr == ADR_MCLR);
  assign rd_stat  = reg_rd && (reg_addr == ADR_CMD);
  assign dreq_eff = dreq_in ^ {NCH{dreq_lo_q}};
  assign elig     = (dreq_eff & ~mask) | (req_sw & blk);
  assign evt      = busy_q && (tc_hit || eop_hit);

  dma_prio_pick #(.NCH(NCH)) pick_i (
    .elig(elig), .rotate(rot_q), .top(top_q), .any(pick_any), .sel(pick_sel)
  );

  dma_chan_regs #(.NCH(NCH)) regs_i (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .rd_stat(rd_stat), .mclr(mclr_w),
    .addr(reg_addr), .wdata(reg_wdata), .evt(evt), .evt_ch(held_q),
    .mask(mask), .req_sw(req_sw), .blk(blk), .tc_flags(tc_flags)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {dis_q, rot_q, dreq_lo_q, dack_hi_q} <= '0;
    end else if (mclr_w) begin
      {dis_q, rot_q, dreq_lo_q, dack_hi_q} <= '0;
    end else if (reg_wr && reg_addr == ADR_CMD) begin
      dis_q     <= reg_wdata[CMD_DIS_BIT];
      rot_q     <= reg_wdata[CMD_ROT_BIT];
      dreq_lo_q <= reg_wdata[CMD_DREQL_BIT];
      dack_hi_q <= reg_wdata[CMD_DACKH_BIT];
    end
  end

  assign req_valid = pick_any && !dis_q && !busy_q;
  assign svc_take  = svc_start && req_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      held_q <= '0;
      top_q  <= '0;
    end else if (mclr_w) begin
      busy_q <= 1'b0;
      top_q  <= '0;
    end else if (svc_take) begin
      busy_q <= 1'b1;
      held_q <= pick_sel;
    end else if (busy_q && svc_done) begin
      busy_q <= 1'b0;
      top_q  <= next_ch(held_q);
    end
  end

  assign win_ch = busy_q ? held_q : pick_sel;

  always_comb begin
    dack_act = '0;
    if (busy_q) dack_act[held_q] = 1'b1;
  end
  assign dack_out     = dack_hi_q ? dack_act : ~dack_act;
  assign status_rdata = {dreq_eff | req_sw, tc_flags};

  assert_fixed_order_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !rot_q && elig[0]) |-> (win_ch == '0));

  assert_rot_lowest_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(busy_q && svc_done) && !$past(mclr_w) && rot_q && req_valid && $countones(elig) > 1)
      |-> (win_ch != $past(held_q)));

  assert_dack_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dack_out ^ {NCH{!dack_hi_q}}));

  assert_no_start_disabled_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(dis_q) && !$past(busy_q) && !$past(mclr_w)) |-> !busy_q);

  assert_hold_winner_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && $past(busy_q)) |-> (win_ch == $past(win_ch) && !req_valid));

  assert_mclr_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $past(mclr_w) |-> (!busy_q && top_q == '0));
endmodule

// File: tb/dma_req_arbiter_tb.sv
module dma_req_arbiter_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0, reg_rd = 1'b0;
  logic [3:0] reg_addr = 4'h0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] status_rdata;
  logic [3:0] dreq_in = 4'h0;
  logic       svc_start = 1'b0, svc_done = 1'b0, tc_hit = 1'b0, eop_hit = 1'b0;
  logic       req_valid;
  logic [1:0] win_ch;
  logic [3:0] dack_out;
  int         n_vec = 0, n_bad = 0;

  localparam logic [3:0] A_CMD = 4'b1000, A_REQ = 4'b1001, A_SMASK = 4'b1010,
                         A_MODE = 4'b1011, A_MCLR = 4'b1101, A_CLRM = 4'b1110,
                         A_AMASK = 4'b1111;

  always #2 clk = ~clk;

  dma_req_arbiter dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .status_rdata(status_rdata), .dreq_in(dreq_in),
    .svc_start(svc_start), .svc_done(svc_done), .tc_hit(tc_hit), .eop_hit(eop_hit),
    .req_valid(req_valid), .win_ch(win_ch), .dack_out(dack_out)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0; #1;
  endtask

  task automatic rd_status(output logic [7:0] v);
    @(negedge clk); reg_rd = 1'b1; reg_addr = A_CMD; #1; v = status_rdata;
    @(negedge clk); reg_rd = 1'b0; #1;
  endtask

  task automatic set_dreq(input logic [3:0] v);
    @(negedge clk); dreq_in = v; #1;
  endtask

  task automatic begin_svc();
    @(negedge clk); svc_start = 1'b1;
    @(negedge clk); svc_start = 1'b0; #1;
  endtask

  task automatic end_svc(input logic tc, input logic eop);
    if (tc || eop) begin
      @(negedge clk); tc_hit = tc; eop_hit = eop;
      @(negedge clk); tc_hit = 1'b0; eop_hit = 1'b0;
    end
    @(negedge clk); svc_done = 1'b1;
    @(negedge clk); svc_done = 1'b0; #1;
  endtask

  task automatic t_reset();
    chk("R5 reset no grant", {7'd0, req_valid}, 8'd0);
    chk("R4 reset dack idle", {4'd0, dack_out}, 8'h0F);
    chk("R8 reset status", status_rdata, 8'h00);
    set_dreq(4'hF);
    chk("R5 masked after reset", {7'd0, req_valid}, 8'd0);
  endtask

  task automatic t_fixed();
    wr(A_CLRM, 8'h00);
    set_dreq(4'b1110);
    chk("R1 valid", {7'd0, req_valid}, 8'd1);
    chk("R1 win ch1", {6'd0, win_ch}, 8'd1);
    set_dreq(4'b1111);
    chk("R1 win ch0", {6'd0, win_ch}, 8'd0);
    set_dreq(4'b1100);
    chk("R1 win ch2", {6'd0, win_ch}, 8'd2);
  endtask

  task automatic t_mask();
    set_dreq(4'b1111);
    wr(A_SMASK, 8'h04);
    chk("R5 single set ch0", {6'd0, win_ch}, 8'd1);
    wr(A_AMASK, 8'h06);
    chk("R5 all-mask load", {6'd0, win_ch}, 8'd0);
    set_dreq(4'b0110);
    chk("R5 masked ignored", {7'd0, req_valid}, 8'd0);
    wr(A_SMASK, 8'h01);
    chk("R5 single clear ch1", {6'd0, win_ch}, 8'd1);
    wr(A_CLRM, 8'h00);
    set_dreq(4'b0000);
  endtask

  task automatic t_dreq_pol();
    wr(A_CMD, 8'h40);
    set_dreq(4'b1011);
    chk("R3 low-active win", {6'd0, win_ch}, 8'd2);
    set_dreq(4'b1111);
    chk("R3 all high idle", {7'd0, req_valid}, 8'd0);
    wr(A_CMD, 8'h00);
    set_dreq(4'b0000);
  endtask

  task automatic t_disable();
    set_dreq(4'b0001);
    wr(A_CMD, 8'h04);
    chk("R9 disabled no valid", {7'd0, req_valid}, 8'd0);
    begin_svc();
    chk("R9 no dack", {4'd0, dack_out}, 8'h0F);
    wr(A_CMD, 8'h00);
    chk("R9 re-enabled", {7'd0, req_valid}, 8'd1);
    set_dreq(4'b0000);
  endtask

  task automatic t_rotate();
    wr(A_CMD, 8'h10);
    set_dreq(4'hF);
    chk("R2 start ch0", {6'd0, win_ch}, 8'd0);
    for (int k = 1; k <= 4; k++) begin
      begin_svc();
      end_svc(1'b0, 1'b0);
      chk($sformatf("R2 rotate step %0d", k), {6'd0, win_ch}, 8'(k % 4));
    end
    begin_svc();
    end_svc(1'b0, 1'b0);
    set_dreq(4'b1001);
    chk("R2 ch0 now lowest", {6'd0, win_ch}, 8'd3);
  endtask

  task automatic t_mclr();
    wr(A_MCLR, 8'h00);
    set_dreq(4'hF);
    chk("R11 mask set", {7'd0, req_valid}, 8'd0);
    chk("R11 dack idle", {4'd0, dack_out}, 8'h0F);
    chk("R11 status", status_rdata, 8'hF0);
    wr(A_CLRM, 8'h00);
    wr(A_CMD, 8'h10);
    set_dreq(4'b1011);
    chk("R11 pointer reset", {6'd0, win_ch}, 8'd0);
    wr(A_CMD, 8'h00);
    set_dreq(4'b0000);
  endtask

  task automatic t_sw_req();
    wr(A_MCLR, 8'h00);
    wr(A_MODE, 8'h02);
    wr(A_REQ, 8'h06);
    chk("R6 non-block ignored", {7'd0, req_valid}, 8'd0);
    chk("R8 pending bit", status_rdata, 8'h40);
    wr(A_MODE, 8'h82);
    chk("R6 block honoured", {7'd0, req_valid}, 8'd1);
    chk("R6 block win ch2", {6'd0, win_ch}, 8'd2);
    wr(A_REQ, 8'h02);
    chk("R6 request reset", {7'd0, req_valid}, 8'd0);
  endtask

  task automatic t_tc();
    logic [7:0] v;
    set_dreq(4'b0000);
    wr(A_MODE, 8'h81);
    wr(A_CLRM, 8'h00);
    wr(A_REQ, 8'h05);
    chk("R6 sw win ch1", {6'd0, win_ch}, 8'd1);
    begin_svc();
    chk("R4 dack low-active", {4'd0, dack_out}, 8'h0D);
    end_svc(1'b1, 1'b0);
    chk("R7 request cleared", {7'd0, req_valid}, 8'd0);
    chk("R7 tc flag", status_rdata, 8'h02);
    set_dreq(4'b0010);
    chk("R7 mask set", {7'd0, req_valid}, 8'd0);
    set_dreq(4'b0000);
    rd_status(v);
    chk("R8 read value", v, 8'h02);
    chk("R8 cleared on read", status_rdata, 8'h00);
  endtask

  task automatic t_autoinit();
    wr(A_MODE, 8'h13);
    wr(A_CLRM, 8'h00);
    set_dreq(4'b1000);
    begin_svc();
    end_svc(1'b0, 1'b1);
    chk("R7 autoinit unmasked", {5'd0, req_valid, win_ch}, 8'h07);
    chk("R7 eop flag", status_rdata, 8'h88);
  endtask

  task automatic t_dack_latch();
    wr(A_CMD, 8'h80);
    set_dreq(4'b1000);
    begin_svc();
    chk("R4 dack high-active", {4'd0, dack_out}, 8'h08);
    set_dreq(4'b0001);
    chk("R10 win held", {6'd0, win_ch}, 8'd3);
    chk("R10 no valid busy", {7'd0, req_valid}, 8'd0);
    chk("R10 dack held", {4'd0, dack_out}, 8'h08);
    end_svc(1'b0, 1'b0);
    chk("R10 released", {5'd0, req_valid, win_ch}, 8'h04);
    chk("R4 dack idle high", {4'd0, dack_out}, 8'h00);
  endtask

  initial begin
    #(4 * 200000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    t_reset();
    t_fixed();
    t_mask();
    t_dreq_pol();
    t_disable();
    t_rotate();
    t_mclr();
    t_sw_req();
    t_tc();
    t_autoinit();
    t_dack_latch();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule